// File: doc/BRIEF.md
# I2C Byte-Array Target with Fault Snapshot Capture

This block is an I2C target that serves a 256-byte array of registers in the manner of a small serial EEPROM. The bus front end is part of the block. It synchronises SCL and SDA to the system clock, detects START and STOP conditions, and pulls SDA low through an open-drain enable. A host can read at the current pointer, read a run of bytes, move the pointer with an address-only write and then read, write one byte, or write a run of bytes.

A second port carries a 27-byte live status vector and a shutdown strobe. On each strobe cycle the vector is copied into array addresses 64 to 90. Only the most recent copy is kept, and it stays there until the host overwrites that region or another strobe replaces it. The array is plain registers. A parameterised busy interval stands in for the internal write time: after a STOP that ends a write carrying data, the target ignores its own address for that many clocks.

The status input is sampled on the strobe cycle and has no back-pressure, so every strobe is taken. A host write that lands in the same cycle as a strobe is held for one cycle and applied after the copy. It therefore survives even inside the snapshot region.

Top module: `eeprom_snap_top`

## Requirements
- R1: The target acknowledges a 7-bit address equal to 4'b1110 followed by `slot_sel[2:0]`. It does not acknowledge any other address, and after a non-matching address it stays off the bus until the next START.
- R2: After reset the pointer is 0. A read transfer returns the byte at the pointer and advances the pointer by one for every byte sent.
- R3: The pointer wraps from 255 to 0, both on reads and on multi-byte writes.
- R4: A write transfer that carries only the address byte loads the pointer and does not start a busy interval. A read that follows at once returns the data from that address.
- R5: In a write transfer the target acknowledges the address byte and every data byte. Each data byte is stored at the pointer, and the pointer then advances.
- R6: After a STOP that ends a write carrying at least one data byte, the target does not acknowledge its address for `BUSY_CYCLES` clocks. After that interval it acknowledges again.
- R7: While `snap_req` is high, status byte k (`status_vec[8k+7:8k]`) is written to array address 64+k, for k = 0..26, one clock later. A later strobe overwrites an earlier copy.
- R8: A host write that coincides with `snap_req` is deferred until the first cycle without a strobe, so the host data ends up in the array.
- R9: A read run ends when the master answers a byte with NACK. The target releases SDA after that NACK and waits for STOP or START.
- R10: `sda_oe` changes only while SCL is low.
- R11: After reset `sda_oe` is 0 and every array byte is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | When 1, the target pulls SDA low |
| slot_sel | input | 3 | Low three bits of the target address |
| status_vec | input | 216 | Live status; byte k in bits 8k+7..8k |
| snap_req | input | 1 | Shutdown strobe that copies status into the array |

## Verification
The target's SDA response (an ACK or a data bit) appears three clocks after SCL falls: two synchroniser stages plus the registered state update. The bench master holds SCL low for ten clocks and samples SDA five clocks into the high phase, well after that point. A snapshot is visible one clock after the strobe. The busy interval starts two clocks after the STOP is detected and lasts `BUSY_CYCLES` clocks, so the bench probes the address immediately after the STOP and again only after waiting `BUSY_CYCLES` plus a margin. A behavioural array model in the bench predicts every byte read back. Every clock it also checks that SDA is free while the bus is idle and that the drive never changes while SCL is high.

// File: rtl/eeprom_snap_pkg.sv
package eeprom_snap_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RX,
    PH_RX_ACK,
    PH_TX,
    PH_TX_ACK
  } phase_t;
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_q,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_hit,
  output logic stop_hit
);
  logic [1:0] raw;
  logic [1:0] synced;
  logic       scl_d, sda_d;

  assign raw = {sda_i, scl_i};

  for (genvar l = 0; l < 2; l++) begin : g_line
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '1;
      else        pipe <= {pipe[STAGES-2:0], raw[l]};
    end
    assign synced[l] = pipe[STAGES-1];
  end

  assign scl_q = synced[0];
  assign sda_q = synced[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_q;
      sda_d <= sda_q;
    end
  end

  assign scl_rise  = scl_q & ~scl_d;
  assign scl_fall  = ~scl_q & scl_d;
  assign start_hit = scl_q & scl_d & sda_d & ~sda_q;
  assign stop_hit  = scl_q & scl_d & ~sda_d & sda_q;
endmodule

// File: rtl/wr_hold_timer.sv
module wr_hold_timer #(
  parameter int CYCLES = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           left <= '0;
    else if (kick)        left <= CW'(CYCLES);
    else if (left != '0)  left <= left - 1'b1;
  end

  assign busy = (left != '0);
endmodule

// File: rtl/snap_store.sv
module snap_store #(
  parameter int DEPTH      = 256,
  parameter int SNAP_BASE  = 64,
  parameter int SNAP_BYTES = 27,
  localparam int AW        = $clog2(DEPTH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  host_we,
  input  logic [AW-1:0]         host_addr,
  input  logic [7:0]            host_data,
  input  logic                  snap_req,
  input  logic [SNAP_BYTES*8-1:0] snap_vec,
  input  logic [AW-1:0]         rd_addr,
  output logic [7:0]            rd_data,
  output logic                  pend_v,
  output logic [7:0]            snap_first,
  output logic [7:0]            snap_last
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] pend_a;
  logic [7:0]    pend_d;
  logic          go_v;
  logic [AW-1:0] go_a;
  logic [7:0]    go_d;

  // a held write goes ahead of a new one; bytes arrive far apart on the bus
  assign go_v = pend_v | host_we;
  assign go_a = pend_v ? pend_a : host_addr;
  assign go_d = pend_v ? pend_d : host_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      pend_v <= 1'b0;
      pend_a <= '0;
      pend_d <= '0;
    end else if (snap_req) begin
      for (int k = 0; k < SNAP_BYTES; k++)
        mem[SNAP_BASE + k] <= snap_vec[k*8 +: 8];
      pend_v <= go_v;
      pend_a <= go_a;
      pend_d <= go_d;
    end else begin
      if (go_v) mem[go_a] <= go_d;
      pend_v <= 1'b0;
    end
  end

  assign rd_data    = mem[rd_addr];
  assign snap_first = mem[SNAP_BASE];
  assign snap_last  = mem[SNAP_BASE + SNAP_BYTES - 1];
endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
  import eeprom_snap_pkg::*;
#(
  parameter int          AW         = 8,
  parameter logic [3:0]  DEV_PREFIX = 4'b1110
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    slot_sel,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          sda_q,
  input  logic          start_hit,
  input  logic          stop_hit,
  input  logic          busy,
  input  logic [7:0]    rd_data,
  output logic          sda_oe,
  output logic [AW-1:0] ptr,
  output logic          host_we,
  output logic [AW-1:0] host_addr,
  output logic [7:0]    host_data,
  output logic          kick,
  output logic          addr_ack
);
  phase_t     ph;
  logic [2:0] bitn;
  logic [7:0] sh;
  logic [7:0] txsh;
  logic       full;
  logic       is_addr;
  logic       want_ptr;
  logic       rd_mode;
  logic       wrote;
  logic       nack;
  logic       hit;

  assign hit = (sh[7:1] == {DEV_PREFIX, slot_sel}) && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph        <= PH_IDLE;
      bitn      <= '0;
      sh        <= '0;
      txsh      <= '0;
      full      <= 1'b0;
      is_addr   <= 1'b0;
      want_ptr  <= 1'b0;
      rd_mode   <= 1'b0;
      wrote     <= 1'b0;
      nack      <= 1'b0;
      sda_oe    <= 1'b0;
      ptr       <= '0;
      host_we   <= 1'b0;
      host_addr <= '0;
      host_data <= '0;
      kick      <= 1'b0;
      addr_ack  <= 1'b0;
    end else begin
      host_we  <= 1'b0;
      kick     <= 1'b0;
      addr_ack <= 1'b0;
      if (stop_hit) begin
        ph     <= PH_IDLE;
        sda_oe <= 1'b0;
        kick   <= wrote;
        wrote  <= 1'b0;
      end else if (start_hit) begin
        ph      <= PH_RX;
        bitn    <= '0;
        full    <= 1'b0;
        is_addr <= 1'b1;
        sda_oe  <= 1'b0;
      end else begin
        case (ph)
          PH_RX: begin
            if (scl_rise) begin
              sh   <= {sh[6:0], sda_q};
              bitn <= bitn + 1'b1;
              if (bitn == 3'd7) full <= 1'b1;
            end
            if (scl_fall && full) begin
              full <= 1'b0;
              if (is_addr) begin
                if (hit) begin
                  sda_oe   <= 1'b1;
                  rd_mode  <= sh[0];
                  is_addr  <= 1'b0;
                  want_ptr <= 1'b1;
                  addr_ack <= 1'b1;
                  ph       <= PH_RX_ACK;
                end else begin
                  ph <= PH_IDLE;
                end
              end else if (want_ptr) begin
                ptr      <= sh[AW-1:0];
                want_ptr <= 1'b0;
                sda_oe   <= 1'b1;
                ph       <= PH_RX_ACK;
              end else begin
                host_we   <= 1'b1;
                host_addr <= ptr;
                host_data <= sh;
                ptr       <= ptr + 1'b1;
                wrote     <= 1'b1;
                sda_oe    <= 1'b1;
                ph        <= PH_RX_ACK;
              end
            end
          end
          PH_RX_ACK: begin
            if (scl_fall) begin
              bitn <= '0;
              if (rd_mode) begin
                txsh   <= rd_data;
                sda_oe <= ~rd_data[7];
                ptr    <= ptr + 1'b1;
                ph     <= PH_TX;
              end else begin
                sda_oe <= 1'b0;
                ph     <= PH_RX;
              end
            end
          end
          PH_TX: begin
            if (scl_fall) begin
              if (bitn == 3'd7) begin
                sda_oe <= 1'b0;
                ph     <= PH_TX_ACK;
              end else begin
                txsh   <= {txsh[6:0], 1'b0};
                sda_oe <= ~txsh[6];
                bitn   <= bitn + 1'b1;
              end
            end
          end
          PH_TX_ACK: begin
            if (scl_rise) nack <= sda_q;
            if (scl_fall) begin
              bitn <= '0;
              if (!nack) begin
                txsh   <= rd_data;
                sda_oe <= ~rd_data[7];
                ptr    <= ptr + 1'b1;
                ph     <= PH_TX;
              end else begin
                ph <= PH_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/eeprom_snap_top.sv
module eeprom_snap_top #(
  parameter int         DEPTH       = 256,
  parameter int         SNAP_BASE   = 64,
  parameter int         SNAP_BYTES  = 27,
  parameter int         BUSY_CYCLES = 300,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_PREFIX  = 4'b1110
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    scl_i,
  input  logic                    sda_i,
  output logic                    sda_oe,
  input  logic [2:0]              slot_sel,
  input  logic [SNAP_BYTES*8-1:0] status_vec,
  input  logic                    snap_req
);
  localparam int AW = $clog2(DEPTH);

  logic          scl_q, sda_q, scl_rise, scl_fall, start_hit, stop_hit;
  logic          busy, kick, addr_ack, host_we, pend_v;
  logic [AW-1:0] ptr, host_addr;
  logic [7:0]    host_data, rd_data, snap_first, snap_last;

  i2c_line_filter #(.STAGES(SYNC_STAGES)) u_line (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_hit(start_hit), .stop_hit(stop_hit)
  );

  i2c_target_fsm #(.AW(AW), .DEV_PREFIX(DEV_PREFIX)) u_fsm (
    .clk(clk), .rst_n(rst_n), .slot_sel(slot_sel),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_q(sda_q),
    .start_hit(start_hit), .stop_hit(stop_hit), .busy(busy),
    .rd_data(rd_data), .sda_oe(sda_oe), .ptr(ptr),
    .host_we(host_we), .host_addr(host_addr), .host_data(host_data),
    .kick(kick), .addr_ack(addr_ack)
  );

  wr_hold_timer #(.CYCLES(BUSY_CYCLES)) u_hold (
    .clk(clk), .rst_n(rst_n), .kick(kick), .busy(busy)
  );

  snap_store #(.DEPTH(DEPTH), .SNAP_BASE(SNAP_BASE), .SNAP_BYTES(SNAP_BYTES)) u_store (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_data(host_data), .snap_req(snap_req), .snap_vec(status_vec),
    .rd_addr(ptr), .rd_data(rd_data), .pend_v(pend_v),
    .snap_first(snap_first), .snap_last(snap_last)
  );
endmodule

// File: rtl/eeprom_snap_chk.sv
module eeprom_snap_chk #(
  parameter int SNAP_BYTES = 27
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    scl_q,
  input logic                    sda_oe,
  input logic                    addr_ack,
  input logic                    busy,
  input logic                    stop_hit,
  input logic                    snap_req,
  input logic                    host_we,
  input logic                    pend_v,
  input logic [SNAP_BYTES*8-1:0] status_vec,
  input logic [7:0]              snap_first,
  input logic [7:0]              snap_last
);
  // R10
  drive_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_q);

  // R6
  no_ack_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_ack |-> !busy);

  // R6
  busy_from_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_hit, 2));

  // R7
  snap_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snap_req |=> (snap_first == $past(status_vec[7:0])) &&
                 (snap_last == $past(status_vec[SNAP_BYTES*8-1 -: 8])));

  // R8
  defer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_req && host_we) |=> pend_v);

  // R8
  defer_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_v && !snap_req) |=> !pend_v);
endmodule

bind eeprom_snap_top eeprom_snap_chk #(.SNAP_BYTES(SNAP_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_q(scl_q), .sda_oe(sda_oe),
  .addr_ack(addr_ack), .busy(busy), .stop_hit(stop_hit),
  .snap_req(snap_req), .host_we(host_we), .pend_v(pend_v),
  .status_vec(status_vec), .snap_first(snap_first), .snap_last(snap_last)
);

// File: tb/sim_eeprom_snap_top.sv
`timescale 1ns/1ps
module sim_eeprom_snap_top;
  localparam int BUSY = 300;
  localparam int NB   = 27;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_bus;
  logic [2:0] slot_sel = 3'b011;
  logic [NB*8-1:0] status_vec = '0;
  logic snap_req = 1'b0;

  int tests = 0;
  int fails = 0;
  bit done = 0;
  bit bus_free = 1;
  int viol_idle = 0;
  int viol_edge = 0;

  logic [7:0] ref_mem [256];
  int ref_ptr = 0;

  always #10 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  eeprom_snap_top #(.BUSY_CYCLES(BUSY)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe(sda_oe), .slot_sel(slot_sel), .status_vec(status_vec),
    .snap_req(snap_req)
  );

  // per-clock watch: SDA free while idle (R11/R9), drive stable while SCL high (R10)
  logic prev_oe = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_free && sda_oe) viol_idle++;
      if (sda_oe !== prev_oe && scl_m) viol_edge++;
    end
    prev_oe = sda_oe;
  end

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    bus_free = 0;
    sda_m = 1; step(5);
    scl_m = 1; step(10);
    sda_m = 0; step(10);
    scl_m = 0; step(5);
  endtask

  task automatic bus_stop();
    sda_m = 0; step(5);
    scl_m = 1; step(10);
    sda_m = 1; step(10);
    bus_free = 1;
  endtask

  task automatic tx_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; step(5);
      scl_m = 1; step(10);
      scl_m = 0; step(5);
    end
    sda_m = 1; step(5);
    scl_m = 1; step(5);
    ack = !sda_bus; step(5);
    scl_m = 0; step(5);
  endtask

  task automatic rx_byte(input logic mack, output logic [7:0] d);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      step(5); scl_m = 1;
      step(5); d[i] = sda_bus;
      step(5); scl_m = 0;
    end
    sda_m = mack ? 1'b0 : 1'b1; step(5);
    scl_m = 1; step(10);
    scl_m = 0; step(5);
    sda_m = 1;
  endtask

  task automatic host_write(input logic [7:0] a, input logic [7:0] d[$]);
    logic ack;
    bus_start();
    tx_byte(8'hE6, ack); chk("R5 address ack on write", ack, 1);
    tx_byte(a, ack);     chk("R5 pointer byte ack", ack, 1);
    ref_ptr = a;
    foreach (d[i]) begin
      tx_byte(d[i], ack); chk("R5 data byte ack", ack, 1);
      ref_mem[ref_ptr] = d[i];
      ref_ptr = (ref_ptr + 1) % 256;
    end
    bus_stop();
  endtask

  task automatic set_ptr(input logic [7:0] a);
    logic ack;
    bus_start();
    tx_byte(8'hE6, ack); chk("R4 address ack", ack, 1);
    tx_byte(a, ack);     chk("R4 pointer byte ack", ack, 1);
    ref_ptr = a;
    bus_stop();
  endtask

  task automatic read_run(input int n, input string tag);
    logic ack;
    logic [7:0] d;
    bus_start();
    tx_byte(8'hE7, ack); chk({tag, " read address ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      rx_byte(i != n - 1, d);
      chk(tag, d, ref_mem[ref_ptr]);
      ref_ptr = (ref_ptr + 1) % 256;
    end
    chk("R9 SDA released after NACK", sda_oe, 0);
    bus_stop();
  endtask

  task automatic snap_model();
    for (int k = 0; k < NB; k++) ref_mem[64 + k] = status_vec[k*8 +: 8];
  endtask

  initial begin
    logic ack;
    for (int i = 0; i < 256; i++) ref_mem[i] = 8'h00;
    step(4);
    rst_n = 1;
    step(4);
    // R11 reset state
    chk("R11 SDA released after reset", sda_oe, 0);

    // R2 current-address read from reset pointer
    read_run(2, "R2 current-address read after reset");

    // R1 foreign address is not acknowledged
    bus_start();
    tx_byte(8'hEA, ack); chk("R1 foreign address NACK", ack, 0);
    bus_stop();
    bus_start();
    tx_byte(8'hE7, ack); chk("R1 own address ACK", ack, 1);
    begin logic [7:0] d; rx_byte(1'b0, d); chk("R2 pointer advanced by read", d, ref_mem[ref_ptr]); end
    ref_ptr = (ref_ptr + 1) % 256;
    bus_stop();

    // R5 multi-byte write, then R6 busy window
    host_write(8'h10, '{8'hA1, 8'hB2, 8'hC3, 8'hD4});
    bus_start();
    tx_byte(8'hE6, ack); chk("R6 address NACK while busy", ack, 0);
    bus_stop();
    step(BUSY + 20);
    bus_start();
    tx_byte(8'hE6, ack); chk("R6 address ACK after busy", ack, 1);
    bus_stop();

    // R4 random read: address-only write then immediate read (no busy)
    set_ptr(8'h10);
    read_run(4, "R4 random read data");

    // R5 single byte write
    host_write(8'h33, '{8'h5C});
    step(BUSY + 20);
    set_ptr(8'h33);
    read_run(1, "R5 byte write readback");

    // R3 write wrap 255 -> 0, then read wrap
    host_write(8'hFE, '{8'h5A, 8'h6B, 8'h7C});
    step(BUSY + 20);
    chk("R3 model wrapped write pointer", ref_ptr, 1);
    set_ptr(8'hFE);
    read_run(3, "R3 read across wrap");
    read_run(1, "R3 pointer continues after wrap");

    // R7 snapshot copy and overwrite
    for (int k = 0; k < NB; k++) status_vec[k*8 +: 8] = 8'h30 + 8'(k);
    snap_req = 1; step(1); snap_model(); snap_req = 0;
    step(2);
    set_ptr(8'd64);
    read_run(NB, "R7 snapshot bytes");
    for (int k = 0; k < NB; k++) status_vec[k*8 +: 8] = 8'h80 + 8'(k);
    snap_req = 1; step(1); snap_model(); snap_req = 0;
    set_ptr(8'd63);
    read_run(5, "R7 newer snapshot replaces older");

    // R8 host write coinciding with a held strobe
    for (int k = 0; k < NB; k++) status_vec[k*8 +: 8] = 8'hC0 + 8'(k);
    bus_start();
    tx_byte(8'hE6, ack); chk("R8 address ack", ack, 1);
    tx_byte(8'd70, ack); chk("R8 pointer ack", ack, 1);
    snap_req = 1;
    snap_model();
    tx_byte(8'hEE, ack); chk("R8 data ack", ack, 1);
    ref_mem[70] = 8'hEE;
    ref_ptr = 71;
    step(3);
    snap_req = 0;
    bus_stop();
    step(BUSY + 20);
    set_ptr(8'd64);
    read_run(8, "R8 host byte kept over snapshot");

    chk("R11 R9 SDA free while bus idle", viol_idle, 0);
    chk("R10 SDA drive changed only with SCL low", viol_edge, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule